// File: doc/BRIEF.md
# Asynchronous Timer Register Update Bridge

This block connects a CPU-side register port to an 8-bit timer that runs from its own slow oscillator clock. Three timer registers cross the boundary: the counter preload, the compare value and the timer control byte. Each register has a private holding register on the CPU side. When the bridge is in asynchronous mode, a CPU write fills the holding register and raises that register's busy flag. A toggle handshake then carries the value into the timer domain, and the busy flag drops once the acknowledge has come back through a two-flop synchronizer.

In the other direction, the live count from the timer core is snapshotted on every oscillator edge and handed to the CPU domain, so a counter read returns the current timer value. Reads of the compare and control registers return their holding registers, so the CPU sees a value as soon as it writes it. A status register holds the three busy flags and the clock-select bit that puts the bridge into asynchronous mode. While a compare or counter transfer is in flight, a match-block output tells the timer core to suppress compare matches. The CPU clock must be more than four times the oscillator frequency.

Top module: `tmr_async_bridge`

## Requirements
- R1: After reset all holding registers, all destination registers, the counter readback, the busy flags and the clock-select bit are zero.
- R2: Register select 3 is status. Reading it gives bit 3 = clock select, bit 2 = counter busy, bit 1 = compare busy, bit 0 = control busy, and zero in bits 7:4. Writing it loads the clock select from data bit 3 and ignores the other bits. The clock select is also driven on `async_sel_o`.
- R3: A write to the counter (select 0), compare (select 1) or control (select 2) register sets that register's busy flag when the clock select is 1 and the flag was clear. The flag reads as 1 in the cycle after the write.
- R4: After an accepted asynchronous write, the destination output still holds its old value after the first rising oscillator edge and holds the new value after the second.
- R5: A busy flag reads 1 while its destination still holds the old value. It returns to 0 only after the destination holds the written value.
- R6: The three registers transfer independently. Writes to two registers on consecutive cycles both reach their destinations, and both busy flags are set at the same time.
- R7: A write to a register whose busy flag is set is ignored. The holding register, the destination and the transfer in progress keep the first value.
- R8: Reading the compare or control register returns the holding register, so the new value is visible before the destination updates.
- R9: Reading the counter returns the timer's live count through a copy refreshed on every oscillator edge. Two reads taken ten oscillator periods apart at the same phase, while the timer counts, differ by exactly 10.
- R10: `tmr_match_block_o` is high while a compare or counter transfer is pending in the timer domain and during the oscillator cycle in which a counter load is presented. It is low when no such transfer is active.
- R11: When the clock select is 0, a write updates the holding register but sets no busy flag and does not change the destination.
- R12: `tmr_cnt_load_o` is a one-oscillator-cycle pulse issued once for each counter transfer and never for compare or control transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Synchronous active-low reset, sampled by both clocks |
| tclk_i | input | 1 | Asynchronous oscillator clock of the timer |
| wr_en_i | input | 1 | CPU write strobe |
| wr_sel_i | input | 2 | Write select: 0 counter, 1 compare, 2 control, 3 status |
| wr_data_i | input | 8 | CPU write data |
| rd_sel_i | input | 2 | Read select, same encoding as the write select |
| rd_data_o | output | 8 | Read data, combinational from rd_sel_i |
| tmr_cnt_i | input | 8 | Live count from the timer core, oscillator domain |
| tmr_cnt_o | output | 8 | Counter preload value, oscillator domain |
| tmr_cnt_load_o | output | 1 | Counter load pulse, oscillator domain |
| tmr_cmp_o | output | 8 | Compare value, oscillator domain |
| tmr_ctl_o | output | 8 | Timer control byte, oscillator domain |
| tmr_match_block_o | output | 1 | Suppress compare matches, oscillator domain |
| async_sel_o | output | 1 | Clock-select bit: 1 = asynchronous mode |

## Verification
The hardest case to reach is the narrow window between the second oscillator edge, when the destination has just loaded, and the moment the acknowledge finishes its two-flop crossing and clears the busy flag. The clock phases are chosen so that oscillator edges fall 1 ns before CPU edges. The bench then samples 2 ns after each oscillator edge, which lets it see the destination change while the flag is still set. Back-to-back writes to one register and to two registers place the second write inside an open transfer, which exercises the ignore rule and the independence of the channels.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
    // Register selects on the CPU port
    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    // Channel index equals busy bit position in the status register
    localparam int NCH         = 3;
    localparam int CH_CTL      = 0;
    localparam int CH_CMP      = 1;
    localparam int CH_CNT      = 2;
    localparam int CLKSEL_BIT  = 3;
    localparam int STAT_USED_W = 4;

    // Map channel index to the register select that addresses it
    function automatic reg_sel_e ch2sel(input int ch);
        case (ch)
            CH_CTL:  return SEL_CTL;
            CH_CMP:  return SEL_CMP;
            default: return SEL_CNT;
        endcase
    endfunction
endpackage

// File: rtl/tbr_sync2.sv
// Two-flop synchronizer for slow or toggle-encoded signals.
// Assumes each input bit changes at most once per several destination clocks.
module tbr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage resynchronization
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/tbr_hold_chan.sv
// CPU-side channel for one register: the holding register, the request toggle
// and the busy flag. Busy is the difference between the request toggle and
// the acknowledge toggle after it has been synchronized back into this domain.
// Assumes ack_sync_i comes from a two-flop synchronizer of the timer's ack.
module tbr_hold_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          async_en_i,
    input  logic          wr_hit_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          ack_sync_i,
    output logic [DW-1:0] hold_o,
    output logic          req_tgl_o,
    output logic          busy_o
);
    logic [DW-1:0] hold_q;
    logic          req_q;

    assign busy_o    = req_q ^ ack_sync_i;
    assign hold_o    = hold_q;
    assign req_tgl_o = req_q;

    // Accept a write only when idle; raise a request only in async mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            req_q  <= 1'b0;
        end else if (wr_hit_i && !busy_o) begin
            hold_q <= wr_data_i;
            if (async_en_i) req_q <= ~req_q;
        end
    end

    p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && !busy_o && async_en_i) |=> busy_o);

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && busy_o) |=> $stable(hold_q));

    p_sync_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && !async_en_i) |=> $stable(req_q));
endmodule

// File: rtl/tbr_dest_chan.sv
// Timer-side channel for one register. The first oscillator edge samples the
// request toggle. The second edge copies the (by then stable) holding register
// into the destination, pulses load and flips the acknowledge toggle.
// Assumes the holding register does not change while a request is open.
module tbr_dest_chan #(
    parameter int DW = 8
) (
    input  logic          tclk,
    input  logic          rst_n,
    input  logic          req_tgl_i,
    input  logic [DW-1:0] hold_i,
    output logic [DW-1:0] dst_o,
    output logic          load_o,
    output logic          ack_tgl_o,
    output logic          pend_o
);
    logic req_s_q;
    logic ack_q;

    assign pend_o    = req_s_q ^ ack_q;
    assign ack_tgl_o = ack_q;

    // Sample the request toggle on each oscillator edge
    always_ff @(posedge tclk) begin
        if (!rst_n) req_s_q <= 1'b0;
        else        req_s_q <= req_tgl_i;
    end

    // Complete a pending transfer: load destination and acknowledge
    always_ff @(posedge tclk) begin
        if (!rst_n) begin
            dst_o  <= '0;
            ack_q  <= 1'b0;
            load_o <= 1'b0;
        end else if (pend_o) begin
            dst_o  <= hold_i;
            ack_q  <= req_s_q;
            load_o <= 1'b1;
        end else begin
            load_o <= 1'b0;
        end
    end

    p_pend_loads_r4: assert property (@(posedge tclk) disable iff (!rst_n)
        pend_o |=> load_o);

    p_load_pulse_r12: assert property (@(posedge tclk) disable iff (!rst_n)
        load_o |=> !load_o);
endmodule

// File: rtl/tbr_cnt_mirror.sv
// Counter readback path. The timer domain snapshots the live count and flips
// a toggle on every oscillator edge. The CPU domain synchronizes the toggle
// and captures the snapshot when it sees the toggle change.
// Assumes the CPU clock is more than four times the oscillator clock, so the
// snapshot is stable when it is captured.
module tbr_cnt_mirror #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          tclk,
    input  logic          rst_n,
    input  logic [DW-1:0] live_i,
    output logic [DW-1:0] mirror_o
);
    logic [DW-1:0] snap_q;
    logic          stgl_q;
    logic          stgl_s;
    logic          stgl_prev_q;

    // Timer side: snapshot and mark each oscillator edge
    always_ff @(posedge tclk) begin
        if (!rst_n) begin
            snap_q <= '0;
            stgl_q <= 1'b0;
        end else begin
            snap_q <= live_i;
            stgl_q <= ~stgl_q;
        end
    end

    tbr_sync2 #(.W(1)) u_tgl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (stgl_q),
        .q    (stgl_s)
    );

    // CPU side: capture the snapshot once per marked oscillator edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stgl_prev_q <= 1'b0;
            mirror_o    <= '0;
        end else begin
            stgl_prev_q <= stgl_s;
            if (stgl_s != stgl_prev_q) mirror_o <= snap_q;
        end
    end
endmodule

// File: rtl/tmr_async_bridge.sv
// Top of the asynchronous timer register bridge. Decodes the CPU port,
// instantiates one CPU/timer channel pair per register, holds the
// clock-select bit and builds the status and read data.
// Assumes one reset asserted for at least two oscillator periods and a CPU
// clock more than four times the oscillator clock.
module tmr_async_bridge
    import tbr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tclk_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [1:0]    rd_sel_i,
    output logic [DW-1:0] rd_data_o,
    input  logic [DW-1:0] tmr_cnt_i,
    output logic [DW-1:0] tmr_cnt_o,
    output logic          tmr_cnt_load_o,
    output logic [DW-1:0] tmr_cmp_o,
    output logic [DW-1:0] tmr_ctl_o,
    output logic          tmr_match_block_o,
    output logic          async_sel_o
);
    localparam logic [NCH-1:0] BLOCK_PEND_MASK = NCH'((1 << CH_CMP) | (1 << CH_CNT));
    localparam logic [NCH-1:0] BLOCK_LOAD_MASK = NCH'(1 << CH_CNT);

    logic [DW-1:0]  hold [NCH];
    logic [DW-1:0]  dst  [NCH];
    logic [NCH-1:0] req_tgl, ack_tgl, ack_sync, busy, pend, load;
    logic [DW-1:0]  cnt_mirror;
    logic [DW-1:0]  status;
    logic           async_q;

    // Clock-select bit, written through the status register
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                                 async_q <= 1'b0;
        else if (wr_en_i && wr_sel_i == SEL_STAT)    async_q <= wr_data_i[CLKSEL_BIT];
    end
    assign async_sel_o = async_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam reg_sel_e CH_SEL = ch2sel(ch);
        logic wr_hit;
        assign wr_hit = wr_en_i && (wr_sel_i == CH_SEL);

        tbr_hold_chan #(.DW(DW)) u_hold (
            .clk       (clk_i),
            .rst_n     (rst_ni),
            .async_en_i(async_q),
            .wr_hit_i  (wr_hit),
            .wr_data_i (wr_data_i),
            .ack_sync_i(ack_sync[ch]),
            .hold_o    (hold[ch]),
            .req_tgl_o (req_tgl[ch]),
            .busy_o    (busy[ch])
        );

        tbr_sync2 #(.W(1)) u_ack_sync (
            .clk  (clk_i),
            .rst_n(rst_ni),
            .d    (ack_tgl[ch]),
            .q    (ack_sync[ch])
        );

        tbr_dest_chan #(.DW(DW)) u_dest (
            .tclk     (tclk_i),
            .rst_n    (rst_ni),
            .req_tgl_i(req_tgl[ch]),
            .hold_i   (hold[ch]),
            .dst_o    (dst[ch]),
            .load_o   (load[ch]),
            .ack_tgl_o(ack_tgl[ch]),
            .pend_o   (pend[ch])
        );
    end

    tbr_cnt_mirror #(.DW(DW)) u_mirror (
        .clk     (clk_i),
        .tclk    (tclk_i),
        .rst_n   (rst_ni),
        .live_i  (tmr_cnt_i),
        .mirror_o(cnt_mirror)
    );

    assign tmr_cnt_o         = dst[CH_CNT];
    assign tmr_cmp_o         = dst[CH_CMP];
    assign tmr_ctl_o         = dst[CH_CTL];
    assign tmr_cnt_load_o    = load[CH_CNT];
    assign tmr_match_block_o = |(pend & BLOCK_PEND_MASK) | |(load & BLOCK_LOAD_MASK);

    // Status image: clock select above the busy flags, upper bits zero
    always_comb begin
        status                  = '0;
        status[NCH-1:0]         = busy;
        status[CLKSEL_BIT]      = async_q;
    end

    // Read mux: live counter copy, holding registers, or status
    always_comb begin
        case (rd_sel_i)
            SEL_CNT: rd_data_o = cnt_mirror;
            SEL_CMP: rd_data_o = hold[CH_CMP];
            SEL_CTL: rd_data_o = hold[CH_CTL];
            default: rd_data_o = status;
        endcase
    end

    p_status_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_sel_i == SEL_STAT) |-> (rd_data_o[DW-1:STAT_USED_W] == '0));
endmodule

// File: tb/tmr_async_bridge_tb_top.sv
module tmr_async_bridge_tb_top;
    logic       clk = 1'b0;
    logic       tclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd3;
    logic [7:0] rd_data, cnt_o, cmp_o, ctl_o;
    logic       cnt_load, match_block, async_sel;
    logic [7:0] core_cnt;

    int checks = 0;
    int errors = 0;
    int load_pulses = 0;
    bit done = 1'b0;

    logic [7:0] q_cnt[$];
    logic [7:0] q_cmp[$];
    logic [7:0] q_ctl[$];
    logic [7:0] last_cnt = 8'd0, last_cmp = 8'd0, last_ctl = 8'd0;

    always #4 clk = ~clk;               // 125 MHz CPU clock
    initial begin #3; forever begin tclk = ~tclk; #20; end end  // 25 MHz

    tmr_async_bridge dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tclk_i(tclk),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .tmr_cnt_i(core_cnt), .tmr_cnt_o(cnt_o), .tmr_cnt_load_o(cnt_load),
        .tmr_cmp_o(cmp_o), .tmr_ctl_o(ctl_o),
        .tmr_match_block_o(match_block), .async_sel_o(async_sel)
    );

    // Simple timer core model: loads on pulse, counts when control bit 0 set
    always_ff @(posedge tclk) begin
        if (!rst_n)       core_cnt <= 8'd0;
        else if (cnt_load) core_cnt <= cnt_o;
        else if (ctl_o[0]) core_cnt <= core_cnt + 8'd1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: one write; pushes the expected destination value when a transfer is due
    task automatic do_write(input logic [1:0] sel, input logic [7:0] val, input bit xfer);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        if (xfer) begin
            case (sel)
                2'd0: q_cnt.push_back(val);
                2'd1: q_cmp.push_back(val);
                default: q_ctl.push_back(val);
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        int n = 0;
        do begin
            @(negedge clk);
            do_read(2'd3, s);
            n++;
        end while (s[2:0] != 3'b000 && n < 200);
        check(s[2:0] == 3'b000, req, s, 0);
    endtask

    // Monitor: destination changes are compared against the scoreboard queues
    always @(negedge tclk) begin
        if (rst_n) begin
            if (cnt_load) load_pulses++;
            if (cmp_o != last_cmp) begin
                if (q_cmp.size() == 0) check(0, "R7 unexpected compare update", cmp_o, last_cmp);
                else check(cmp_o == q_cmp.pop_front(), "R6 compare dest", cmp_o, 0);
                last_cmp = cmp_o;
            end
            if (ctl_o != last_ctl) begin
                if (q_ctl.size() == 0) check(0, "R7 unexpected control update", ctl_o, last_ctl);
                else check(ctl_o == q_ctl.pop_front(), "R6 control dest", ctl_o, 0);
                last_ctl = ctl_o;
            end
            if (cnt_o != last_cnt) begin
                if (q_cnt.size() == 0) check(0, "R7 unexpected counter update", cnt_o, last_cnt);
                else check(cnt_o == q_cnt.pop_front(), "R6 counter dest", cnt_o, 0);
                last_cnt = cnt_o;
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, a, b;
        repeat (12) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        do_read(2'd3, v); check(v == 8'h00, "R1 status", v, 0);
        do_read(2'd1, v); check(v == 8'h00, "R1 compare hold", v, 0);
        do_read(2'd2, v); check(v == 8'h00, "R1 control hold", v, 0);
        do_read(2'd0, v); check(v == 8'h00, "R1 counter read", v, 0);
        check({cnt_o, cmp_o, ctl_o} == 24'h0, "R1 destinations", {cnt_o, cmp_o, ctl_o}, 0);

        // R11: synchronous mode write stays local
        do_write(2'd1, 8'h33, 1'b0);
        do_read(2'd3, v); check(v == 8'h00, "R11 no busy", v, 0);
        do_read(2'd1, v); check(v == 8'h33, "R11 holding", v, 8'h33);
        repeat (4) @(posedge tclk);
        #2 check(cmp_o == 8'h00, "R11 dest unchanged", cmp_o, 0);

        // R2: clock select via status, upper bits ignored
        do_write(2'd3, 8'hF8, 1'b0);
        do_read(2'd3, v); check(v == 8'h08, "R2 status image", v, 8'h08);
        check(async_sel == 1'b1, "R2 async_sel_o", async_sel, 1);

        // R4, R5, R10: exact transfer timing for compare
        do_write(2'd1, 8'h44, 1'b1);
        rd_sel = 2'd3;
        @(posedge tclk); #2;
        check(cmp_o == 8'h00, "R4 old after first edge", cmp_o, 0);
        check(match_block == 1'b1, "R10 block while compare pending", match_block, 1);
        @(posedge tclk); #2;
        check(cmp_o == 8'h44, "R4 new after second edge", cmp_o, 8'h44);
        check(rd_data[1] == 1'b1, "R5 still busy at load", rd_data[1], 1);
        wait_idle("R5 busy clears");
        check(cmp_o == 8'h44, "R5 dest at clear", cmp_o, 8'h44);

        // R3, R8: busy set next cycle; holding visible before transfer
        do_write(2'd2, 8'h22, 1'b1);
        do_read(2'd3, v); check(v[0] == 1'b1, "R3 control busy", v, 8'h09);
        do_read(2'd2, v); check(v == 8'h22, "R8 control reads holding", v, 8'h22);
        check(ctl_o == 8'h00, "R8 dest still old", ctl_o, 0);
        wait_idle("R3 idle");

        // R6: two channels in flight together
        do_write(2'd1, 8'h55, 1'b1);
        do_write(2'd2, 8'h66, 1'b1);
        do_read(2'd3, v); check(v[1:0] == 2'b11, "R6 both busy", v[1:0], 3);
        wait_idle("R6 idle");
        check(cmp_o == 8'h55 && ctl_o == 8'h66, "R6 both delivered", {cmp_o, ctl_o}, 16'h5566);

        // R7: second write while busy is dropped
        do_write(2'd2, 8'h70, 1'b1);
        do_write(2'd2, 8'h71, 1'b0);
        do_read(2'd2, v); check(v == 8'h70, "R7 holding keeps first", v, 8'h70);
        wait_idle("R7 idle");
        check(ctl_o == 8'h70, "R7 dest keeps first", ctl_o, 8'h70);

        // R12, R10: counter transfer pulse and match blocking
        do_write(2'd0, 8'h5A, 1'b1);
        @(posedge tclk); #2;
        check(match_block == 1'b1, "R10 block while counter pending", match_block, 1);
        check(cnt_load == 1'b0, "R12 no early load", cnt_load, 0);
        @(posedge tclk); #2;
        check(cnt_load == 1'b1, "R12 load pulse", cnt_load, 1);
        check(match_block == 1'b1, "R10 block during load", match_block, 1);
        @(posedge tclk); #2;
        check(cnt_load == 1'b0, "R12 single pulse", cnt_load, 0);
        check(match_block == 1'b0, "R10 block released", match_block, 0);
        wait_idle("R12 idle");
        repeat (4) @(posedge tclk);
        @(negedge clk);
        do_read(2'd0, v); check(v == 8'h5A, "R9 counter readback held", v, 8'h5A);

        // R9: running counter, two reads ten periods apart at the same phase
        do_write(2'd2, 8'h01, 1'b1);
        wait_idle("R9 idle");
        repeat (3) @(posedge tclk);
        #21 do_read(2'd0, a);
        repeat (10) @(posedge tclk);
        #21 do_read(2'd0, b);
        check(8'(b - a) == 8'd10, "R9 live count delta", 8'(b - a), 10);

        // R2: clear clock select
        do_write(2'd3, 8'h00, 1'b0);
        do_read(2'd3, v); check(v == 8'h00, "R2 status cleared", v, 0);
        check(async_sel == 1'b0, "R2 async_sel_o cleared", async_sel, 0);

        repeat (4) @(posedge tclk);
        @(negedge clk);
        check(q_cnt.size() + q_cmp.size() + q_ctl.size() == 0, "R6 scoreboard drained",
              q_cnt.size() + q_cmp.size() + q_ctl.size(), 0);
        check(load_pulses == 1, "R12 load pulse count", load_pulses, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule